// File: doc/BRIEF.md
# Set-Associative Recency Tag Lookup

This block is the tag side of a set-associative cache, and it only classifies accesses. Each request carries a byte address and an access size in bytes. The block answers hit or miss. It stores no data, and reads and writes are handled the same way: every access allocates. Three parameters set the geometry: total capacity, associativity and line size, each a power of two. The set count follows from them.

Every set is kept as a list ordered by recency. Position 0 holds the most recently used entry. A hit moves its entry to the front. A miss pushes every entry back one place, drops the last one, and puts the new block at the front. The stored tag is the whole block number, not only the bits above the set index.

A request whose bytes cross into the next line looks up both lines on consecutive cycles. It gives one combined answer. A request that reaches more than one line past its first byte is illegal. It sets a sticky error flag.

Top module: `lru_tag_lookup`

## Requirements
- R1: The cache has CACHE_BYTES/LINE_BYTES/WAYS sets. Block number = address >> log2(LINE_BYTES). Set index = the low log2(sets) bits of the block number.
- R2: The tag stored and compared is the complete block number. Two blocks that share a set index but differ in higher bits never hit on each other's entry.
- R3: A hit at recency position 0 leaves the set unchanged. A hit at position i > 0 moves entries 0..i-1 back by one and puts the hit block at position 0.
- R4: A miss moves every entry of the set back by one, discards the entry in the last way, and writes the new block number into position 0. With WAYS = 1 a miss simply replaces the only entry.
- R5: A request inside one line is accepted while req_ready is high. Exactly one cycle after acceptance, rsp_valid is high for one cycle, and rsp_miss is 1 for a miss and 0 for a hit.
- R6: When block(addr+size-1) equals block(addr)+1, both lines are looked up and both sets are updated, whatever the first line's result was. rsp_miss is 1 if either line missed and 0 only if both hit.
- R7: After a two-line request is accepted, req_ready and rsp_valid are low in the next cycle. rsp_valid rises one cycle later, and req_ready is high again in that same cycle.
- R8: A request whose last byte lies two or more blocks past its first is accepted but produces no response. It leaves the tag state unchanged and sets err_flag, which stays high until reset.
- R9: Reset clears every tag entry to zero, raises req_ready, and clears rsp_valid and err_flag. Because of this, the first access to block 0 after reset is a hit.
- R10: A size of 0 is treated as a single byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | SIZE_W | Access size in bytes (0 taken as 1) |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_miss | output | 1 | 1 = miss, 0 = hit; valid with rsp_valid |
| err_flag | output | 1 | Sticky: an illegal multi-line request was seen |

## Verification
The hardest case to reach is a two-line request where the second line's set has just been reordered by the first lookup or by a recent eviction. That case needs two specific sets to be in known recency states at the same moment. The bench runs a small 4-set, 4-way geometry. It first sweeps every block of a 64-block window, then runs directed fill-and-evict sequences on single sets, then issues thousands of pseudo-random requests. Those random requests cover 32 blocks with every offset and sizes up to 17 bytes, so crossing requests land on sets with every recency arrangement. A reference list model in the bench predicts each result.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SECOND = 1'b1
  } lru_state_e;
endpackage

// File: rtl/lru_addr_split.sv
// Splits a byte request into first and last block numbers and classifies the span.
module lru_addr_split #(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 6,
  parameter int OFF_W  = 4,
  parameter int BLK_W  = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic [BLK_W-1:0]  blk_first,
  output logic [BLK_W-1:0]  blk_second,
  output logic              span_two,
  output logic              span_bad
);
  logic [ADDR_W:0] len_m1;
  logic [ADDR_W:0] last_byte;
  logic [BLK_W:0]  last_blk;
  logic [BLK_W:0]  diff;

  always_comb begin
    // size 0 behaves as a single byte (R10)
    if (size == '0) len_m1 = '0;
    else            len_m1 = (ADDR_W+1)'(size) - (ADDR_W+1)'(1);
    last_byte  = {1'b0, addr} + len_m1;
    last_blk   = last_byte[ADDR_W:OFF_W];
    blk_first  = addr[ADDR_W-1:OFF_W];
    blk_second = last_blk[BLK_W-1:0];
    diff       = last_blk - {1'b0, blk_first};
    span_two   = (diff == (BLK_W+1)'(1));
    span_bad   = (diff >  (BLK_W+1)'(1));
  end
endmodule

// File: rtl/lru_set_update.sv
// Compares a tag against one recency-ordered set and forms the reordered row.
module lru_set_update #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 12
) (
  input  logic [WAYS-1:0][TAG_W-1:0] row_in,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAYS-1:0][TAG_W-1:0] row_out
);
  logic [WAYS-1:0] match;
  logic [WAYS-1:0] none_before;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = (row_in[g] == tag);
    end

    assign none_before[0] = 1'b1;
    assign row_out[0]     = tag;

    for (g = 1; g < WAYS; g++) begin : g_shift
      // entry g moves back when no match lies strictly in front of it
      assign none_before[g] = none_before[g-1] & ~match[g-1];
      assign row_out[g]     = none_before[g] ? row_in[g-1] : row_in[g];
    end
  endgenerate

  assign hit = |match;
endmodule

// File: rtl/lru_tag_lookup.sv
module lru_tag_lookup
  import lru_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SIZE_W      = 6,
  parameter int CACHE_BYTES = 256,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              rsp_valid,
  output logic              rsp_miss,
  output logic              err_flag
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SETS  = CACHE_BYTES / LINE_BYTES / WAYS;
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int BLK_W = ADDR_W - OFF_W;

  typedef logic [WAYS-1:0][BLK_W-1:0] row_t;

  lru_state_e        state_q, state_d;
  row_t [SETS-1:0]   tag_q, tag_d;
  logic [BLK_W-1:0]  pend_blk_q, pend_blk_d;
  logic              pend_miss_q, pend_miss_d, pend_en;
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_miss_q, rsp_miss_d;
  logic              err_q, err_d;

  logic [BLK_W-1:0]  blk_first, blk_second, cur_blk;
  logic              span_two, span_bad;
  logic              accept, lkp_en, hit;
  logic [IDX_W-1:0]  cur_set;
  row_t              row_cur, row_upd;

  lru_addr_split #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W), .BLK_W(BLK_W)
  ) u_split (
    .addr(req_addr), .size(req_size),
    .blk_first(blk_first), .blk_second(blk_second),
    .span_two(span_two), .span_bad(span_bad)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;

  // lookup source: incoming request or the pending second line
  always_comb begin
    if (state_q == ST_IDLE) begin
      cur_blk = blk_first;
      lkp_en  = accept & ~span_bad;
    end else begin
      cur_blk = pend_blk_q;
      lkp_en  = 1'b1;
    end
  end

  generate
    if (SETS > 1) begin : g_idx
      assign cur_set = cur_blk[IDX_W-1:0];
    end else begin : g_one_set
      assign cur_set = '0;
    end
  endgenerate

  assign row_cur = tag_q[cur_set];

  lru_set_update #(.WAYS(WAYS), .TAG_W(BLK_W)) u_upd (
    .row_in(row_cur), .tag(cur_blk), .hit(hit), .row_out(row_upd)
  );

  // next state
  always_comb begin
    tag_d       = tag_q;
    state_d     = state_q;
    pend_blk_d  = pend_blk_q;
    pend_miss_d = pend_miss_q;
    pend_en     = 1'b0;
    rsp_valid_d = 1'b0;
    rsp_miss_d  = rsp_miss_q;
    err_d       = err_q | (accept & span_bad);
    if (lkp_en) tag_d[cur_set] = row_upd;
    case (state_q)
      ST_IDLE: begin
        if (accept && !span_bad) begin
          if (span_two) begin
            state_d     = ST_SECOND;
            pend_blk_d  = blk_second;
            pend_miss_d = ~hit;
            pend_en     = 1'b1;
          end else begin
            rsp_valid_d = 1'b1;
            rsp_miss_d  = ~hit;
          end
        end
      end
      default: begin
        state_d     = ST_IDLE;
        rsp_valid_d = 1'b1;
        rsp_miss_d  = pend_miss_q | ~hit;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      tag_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_miss_q  <= 1'b0;
      err_q       <= 1'b0;
      pend_blk_q  <= '0;
      pend_miss_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      err_q       <= err_d;
      if (lkp_en)      tag_q      <= tag_d;
      if (rsp_valid_d) rsp_miss_q <= rsp_miss_d;
      if (pend_en) begin
        pend_blk_q  <= pend_blk_d;
        pend_miss_q <= pend_miss_d;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_miss  = rsp_miss_q;
  assign err_flag  = err_q;
endmodule

// File: rtl/lru_tag_lookup_chk.sv
module lru_tag_lookup_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic err_flag,
  input logic span_two,
  input logic span_bad
);
  a_r5_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !span_two && !span_bad) |=> rsp_valid);

  a_r7_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && span_two && !span_bad) |=> (!req_ready && !rsp_valid));

  a_r7_rsp_late: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && span_two && !span_bad) |=> ##1 (rsp_valid && req_ready));

  a_r8_bad_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && span_bad) |=> (!rsp_valid && err_flag));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

bind lru_tag_lookup lru_tag_lookup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .err_flag(err_flag),
  .span_two(span_two), .span_bad(span_bad)
);

// File: tb/lru_tag_lookup_bench.sv
module lru_tag_lookup_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W = 16;
  localparam int SIZE_W = 6;
  localparam int NSETS  = 4;
  localparam int NWAYS  = 4;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [SIZE_W-1:0] req_size;
  logic              rsp_valid;
  logic              rsp_miss;
  logic              err_flag;

  int tests = 0;
  int fails = 0;
  int model [NSETS][NWAYS];
  bit exp_err = 0;
  int unsigned lfsr = 32'h1d2c3b4a;

  lru_tag_lookup #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CACHE_BYTES(256), .WAYS(NWAYS), .LINE_BYTES(16)
  ) u_lru_tag_lookup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_miss(rsp_miss), .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference recency list: set = block mod 4, tag = full block number
  task automatic model_ref(input int blk, output bit miss);
    int s;
    int p;
    s = blk % NSETS;
    p = NWAYS - 1;
    miss = 1'b1;
    for (int i = 0; i < NWAYS; i++) begin
      if (miss && model[s][i] == blk) begin
        p = i;
        miss = 1'b0;
      end
    end
    for (int j = p; j > 0; j--) model[s][j] = model[s][j-1];
    model[s][0] = blk;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_size = '0;
    exp_err = 1'b0;
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) model[s][w] = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready in reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R9 rsp_valid in reset", int'(rsp_valid), 0);
    chk(err_flag == 1'b0, "R9 err in reset", int'(err_flag), 0);
    rst_n = 1'b1;
  endtask

  task automatic issue(input int addr, input int size, input string req);
    int b1;
    int b2;
    int last;
    bit m1;
    bit m2;
    b1 = addr / 16;
    last = addr + ((size == 0) ? 0 : size - 1);
    b2 = last / 16;
    @(negedge clk);
    chk(req_ready == 1'b1, {req, " ready idle"}, int'(req_ready), 1);
    req_valid = 1'b1;
    req_addr = ADDR_W'(addr);
    req_size = SIZE_W'(size);
    @(negedge clk);
    req_valid = 1'b0;
    if (b2 - b1 > 1) begin
      exp_err = 1'b1;
      chk(rsp_valid == 1'b0, {req, " R8 no response"}, int'(rsp_valid), 0);
      chk(err_flag == 1'b1, {req, " R8 err set"}, int'(err_flag), 1);
    end else if (b2 == b1) begin
      model_ref(b1, m1);
      chk(rsp_valid == 1'b1 && rsp_miss == m1, {req, " R5 result"},
          int'({rsp_valid, rsp_miss}), int'({1'b1, m1}));
      chk(err_flag == exp_err, {req, " err level"}, int'(err_flag), int'(exp_err));
    end else begin
      model_ref(b1, m1);
      model_ref(b2, m2);
      chk(rsp_valid == 1'b0 && req_ready == 1'b0, {req, " R7 busy cycle"},
          int'({rsp_valid, req_ready}), 0);
      @(negedge clk);
      chk(rsp_valid == 1'b1 && req_ready == 1'b1 && rsp_miss == (m1 | m2),
          {req, " R6 combined result"}, int'({rsp_valid, req_ready, rsp_miss}),
          int'({1'b1, 1'b1, m1 | m2}));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R9: zeroed tags make block 0 a hit
    issue(0, 1, "R9 block0 hit after reset");
    // R1 R2: sweep 64 blocks, all sets, tags aliasing on index bits
    for (int b = 0; b < 64; b++) issue(b * 16 + 3, 4, "R1 R2 sweep");
    // R3 R4: directed recency in set 1
    do_reset();
    issue(16 * 1, 1, "R4 fill");
    issue(16 * 5, 1, "R4 fill");
    issue(16 * 9, 1, "R4 fill");
    issue(16 * 13, 1, "R4 fill");
    issue(16 * 13, 1, "R3 hit pos0");
    issue(16 * 1, 1, "R3 hit last pos");
    issue(16 * 17, 1, "R4 evict lru");
    issue(16 * 5, 1, "R4 evicted block misses");
    issue(16 * 1, 1, "R3 hit after reorder");
    // R6 R7: crossing requests, including one miss/one hit
    issue(16 * 1 + 12, 8, "R6 cross hit+miss");
    issue(16 * 2 + 15, 2, "R6 cross");
    issue(16 * 2 + 15, 2, "R6 cross both hit");
    // R10: size 0 at last byte of a line stays single-line
    issue(16 * 2 + 15, 0, "R10 size zero");
    // pseudo-random mix
    for (int n = 0; n < 3000; n++) begin
      int a;
      int sz;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      a  = int'(lfsr % 512);
      sz = int'((lfsr >> 12) % 18);
      issue(a, sz, "R6 random");
    end
    // R8: illegal span, then state unchanged and flag sticky
    issue(5, 40, "R8 illegal");
    issue(16 * 2 + 4, 1, "R8 state untouched");
    issue(16 * 3 + 14, 4, "R8 sticky cross");
    chk(err_flag == 1'b1, "R8 still set", int'(err_flag), 1);
    do_reset();
    @(negedge clk);
    chk(err_flag == 1'b0, "R8 cleared by reset", int'(err_flag), 0);
    issue(0, 1, "R9 block0 hit after second reset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule